// File: doc/BRIEF.md
# Shared-Engine Protection Delay Timer Bank

This block provides a bank of delay timers for protection scheme logic. All of them are served by a single counting datapath. A divider turns the system clock into a service tick. On every tick a scanner visits the channels one per clock cycle, in ascending index order. On its visit, a channel's count advances by one if its run bit is high. When the count reaches the channel's terminal value, the channel's run-out flag is set. The flag and the count then hold until the channel is reset.

The control side owns three kinds of input:
- a level run bit for each channel;
- a one-cycle reset request for each channel, which is latched until that channel's next visit;
- a small switch value for each settable delay channel, which multiplies that channel's base length.

The channels fall into four groups, by index:
- The lowest indices are the settable delay channels.
- The next indices are the long channels.
- The highest index is the slow self-check channel.
- The channels left over are single-register channels.

Long channels chain two count registers, which gives a 16-bit count. The self-check channel chains three.

Top module: `prot_timer_bank`

## Requirements
- R1: A service tick occurs every TICK_DIV clock cycles, and the first tick starts TICK_DIV cycles after reset is released. After each tick, channel c is visited on clock c of the sweep. Its state is updated only at the end of that visit. The outcome is that the update of visit n (n ≥ 1) lands on rising edge n·TICK_DIV + 1 + c after reset release.
- R2: A channel's count advances only on a visit where its run bit run_i[c] is 1. If run_i[c] is 0 at a visit, the count holds, and counting resumes from the held count when the bit returns to 1.
- R3: With terminal value T ≥ 1, runout_o[c] rises at the end of the T-th counting visit. With T = 0 it rises at the first counting visit. Once set, runout_o[c] stays 1 (and the count stays at T) until a reset is serviced.
- R4: A one-cycle pulse on rst_req_i[c] is latched. At channel c's next visit, both the count and runout_o[c] are cleared. Until that visit, runout_o[c] is unchanged.
- R5: If a reset is pending at a visit where run_i[c] is 1, the reset wins and no counting happens at that visit. Counting starts at the following visit.
- R6: Long channels (indices N_MUL to N_MUL+N_LONG-1) and the settable channels use two chained 8-bit registers, with the upper one incremented on a carry out of the lower one. The last channel chains SC_REGS registers. Terminal values above 255 therefore run out at the right visit.
- R7: Settable channel k (k < N_MUL) uses as its terminal value its base length multiplied by the 4-bit switch value mult_i[k]. A switch value of 0 sets run-out at the first counting visit.
- R8: Channels are independent. Running, stopping or resetting one channel never changes another channel's run-out flag.
- R9: While rst_ni is low, and right after it is released, every runout_o bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | N_CH | Run bit of each channel (level) |
| rst_req_i | input | N_CH | Reset request of each channel (pulse, latched) |
| mult_i | input | N_MUL×4 | Switch multiplier of each settable channel |
| runout_o | output | N_CH | Run-out flag of each channel |

## Verification
The bench builds the bank with six channels and a 7-cycle tick. This places every channel group in reach:
- one settable channel with a base of 3;
- one long channel and a three-register self-check channel, each with a terminal of 300, so that the count carries across a register boundary;
- single-register channels with terminals of 4, 1 and 0.

Because the tick is this short, the bench can sweep the switch value through all sixteen codes. It also predicts the exact visit edge for every channel and compares every run-out flag against that prediction on every cycle. This exposes a visit that lands one slot early or late, a reset that wins or loses against a run request, and a lost carry.

// File: rtl/ptb_pkg.sv
package ptb_pkg;

  // number of chained count registers per channel
  function automatic int unsigned ch_regs(int unsigned c, int unsigned n_ch,
                                          int unsigned n_mul, int unsigned n_long,
                                          int unsigned sc_regs);
    if (c == n_ch - 1)            return sc_regs;
    else if (c < n_mul + n_long)  return 2;
    else                          return 1;
  endfunction

endpackage

// File: rtl/ptb_tick.sv
module ptb_tick #(
  parameter int unsigned DIV = 98700
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DW-1:0] div_q;

  assign tick_o = (div_q == DW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

endmodule

// File: rtl/ptb_scan.sv
module ptb_scan #(
  parameter int unsigned N_CH = 17
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  output logic                    act_o,
  output logic [$clog2(N_CH)-1:0] slot_o
);
  localparam int unsigned SW = $clog2(N_CH);

  logic          act_q;
  logic [SW-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      slot_q <= '0;
    end else if (tick_i) begin
      act_q  <= 1'b1;
      slot_q <= '0;
    end else if (act_q) begin
      if (slot_q == SW'(N_CH - 1)) act_q  <= 1'b0;
      else                         slot_q <= slot_q + 1'b1;
    end
  end

  assign act_o  = act_q;
  assign slot_o = slot_q;

  // a sweep must finish before the next tick
  AST_TICK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> !act_q); // R1
  AST_SLOT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> (slot_q <= SW'(N_CH - 1))); // R1

endmodule

// File: rtl/ptb_engine.sv
module ptb_engine #(
  parameter int unsigned REG_W   = 8,
  parameter int unsigned SC_REGS = 3,
  localparam int unsigned CW     = REG_W * SC_REGS,
  localparam int unsigned NR_W   = $clog2(SC_REGS + 1)
) (
  input  logic [CW-1:0]   cnt_i,
  input  logic [CW-1:0]   term_i,
  input  logic [NR_W-1:0] nregs_i,
  input  logic            run_i,
  input  logic            rst_i,
  input  logic            ro_i,
  output logic [CW-1:0]   cnt_o,
  output logic            ro_o
);
  logic [CW-1:0] inc;
  logic          cy;

  // byte-wise ripple: upper register steps on carry out of the lower one
  always_comb begin
    inc = '0;
    cy  = 1'b1;
    for (int b = 0; b < int'(SC_REGS); b++) begin
      {cy, inc[b*REG_W +: REG_W]} = {1'b0, cnt_i[b*REG_W +: REG_W]} + {{REG_W{1'b0}}, cy};
      if (b >= int'(nregs_i)) inc[b*REG_W +: REG_W] = '0;
    end
  end

  always_comb begin
    cnt_o = cnt_i;
    ro_o  = ro_i;
    if (rst_i) begin
      cnt_o = '0;
      ro_o  = 1'b0;
    end else if (run_i && !ro_i) begin
      if (term_i == '0 || inc >= term_i) begin
        cnt_o = term_i;
        ro_o  = 1'b1;
      end else begin
        cnt_o = inc;
      end
    end
  end

endmodule

// File: rtl/ptb_chan.sv
module ptb_chan #(
  parameter int unsigned BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          svc_i,
  input  logic          rst_req_i,
  input  logic [BW-1:0] cnt_nxt_i,
  input  logic          ro_nxt_i,
  output logic          rst_eff_o,
  output logic [BW-1:0] cnt_o,
  output logic          ro_o
);
  logic [BW-1:0] cnt_q;
  logic          ro_q;
  logic          pend_q;

  // a request in the visit cycle is taken by that visit
  assign rst_eff_o = pend_q | rst_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      ro_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= svc_i ? 1'b0 : rst_eff_o;
      if (svc_i) begin
        cnt_q <= cnt_nxt_i;
        ro_q  <= ro_nxt_i;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign ro_o  = ro_q;

endmodule

// File: rtl/prot_timer_bank.sv
module prot_timer_bank #(
  parameter int unsigned N_CH     = 17,
  parameter int unsigned N_MUL    = 2,
  parameter int unsigned N_LONG   = 2,
  parameter int unsigned REG_W    = 8,
  parameter int unsigned SC_REGS  = 3,
  parameter int unsigned MUL_W    = 4,
  parameter int unsigned TICK_DIV = 98700,
  parameter logic [N_CH-1:0][31:0] TERM_TBL = {
    32'd612766,
    32'd15, 32'd5, 32'd25, 32'd122, 32'd101, 32'd31,
    32'd71, 32'd10, 32'd122, 32'd46, 32'd46, 32'd51,
    32'd55724, 32'd2786,
    32'd10, 32'd5
  }
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_CH-1:0]             run_i,
  input  logic [N_CH-1:0]             rst_req_i,
  input  logic [N_MUL-1:0][MUL_W-1:0] mult_i,
  output logic [N_CH-1:0]             runout_o
);
  localparam int unsigned CW   = REG_W * SC_REGS;
  localparam int unsigned SW   = $clog2(N_CH);
  localparam int unsigned NR_W = $clog2(SC_REGS + 1);

  logic                       tick;
  logic                       act;
  logic [SW-1:0]              slot;
  logic [N_CH-1:0]            svc;
  logic [N_CH-1:0]            rst_eff;
  logic [N_CH-1:0][CW-1:0]    cnt_all;
  logic [N_CH-1:0][CW-1:0]    term_all;
  logic [N_CH-1:0][NR_W-1:0]  nregs_all;

  logic [CW-1:0]   cnt_sel, term_sel, cnt_nxt;
  logic [NR_W-1:0] nregs_sel;
  logic            run_sel, rst_sel, ro_sel, ro_nxt;

  ptb_tick #(.DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  ptb_scan #(.N_CH(N_CH)) u_scan (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .act_o  (act),
    .slot_o (slot)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam int unsigned NR = ptb_pkg::ch_regs(c, N_CH, N_MUL, N_LONG, SC_REGS);
    localparam int unsigned BW = NR * REG_W;

    assign svc[c]       = act && (slot == SW'(c));
    assign nregs_all[c] = NR_W'(NR);

    if (c < N_MUL) begin : g_mul
      assign term_all[c] = TERM_TBL[c][CW-1:0] * {{(CW-MUL_W){1'b0}}, mult_i[c]};
    end else begin : g_fix
      assign term_all[c] = TERM_TBL[c][CW-1:0];
    end

    ptb_chan #(.BW(BW)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .svc_i     (svc[c]),
      .rst_req_i (rst_req_i[c]),
      .cnt_nxt_i (cnt_nxt[BW-1:0]),
      .ro_nxt_i  (ro_nxt),
      .rst_eff_o (rst_eff[c]),
      .cnt_o     (cnt_all[c][BW-1:0]),
      .ro_o      (runout_o[c])
    );

    if (BW < CW) begin : g_pad
      assign cnt_all[c][CW-1:BW] = '0;
    end

    AST_RO_AT_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(runout_o[c]) |-> $past(act && slot == SW'(c))); // R3
    AST_RO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (runout_o[c] && !(svc[c] && rst_eff[c])) |=> runout_o[c]); // R3
    AST_RST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (svc[c] && rst_eff[c]) |=> (!runout_o[c] && cnt_all[c] == '0)); // R4
    AST_RST_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (svc[c] && rst_eff[c] && run_i[c]) |=> (cnt_all[c] == '0)); // R5
    AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(act && slot == SW'(c)) |=> $stable(cnt_all[c])); // R8
  end

  // channel mux into the shared engine
  always_comb begin
    cnt_sel   = '0;
    term_sel  = '0;
    nregs_sel = '0;
    run_sel   = 1'b0;
    rst_sel   = 1'b0;
    ro_sel    = 1'b0;
    for (int c = 0; c < int'(N_CH); c++) begin
      if (slot == SW'(c)) begin
        cnt_sel   = cnt_all[c];
        term_sel  = term_all[c];
        nregs_sel = nregs_all[c];
        run_sel   = run_i[c];
        rst_sel   = rst_eff[c];
        ro_sel    = runout_o[c];
      end
    end
  end

  ptb_engine #(.REG_W(REG_W), .SC_REGS(SC_REGS)) u_eng (
    .cnt_i   (cnt_sel),
    .term_i  (term_sel),
    .nregs_i (nregs_sel),
    .run_i   (run_sel),
    .rst_i   (rst_sel),
    .ro_i    (ro_sel),
    .cnt_o   (cnt_nxt),
    .ro_o    (ro_nxt)
  );

  AST_TERM_FITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act |-> ((term_sel >> (int'(nregs_sel) * REG_W)) == '0)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && run_sel && !rst_sel && !ro_sel) |-> (ro_nxt || cnt_nxt > cnt_sel)); // R6

endmodule

// File: tb/sim_prot_timer_bank.sv
`timescale 1ns/1ps
module sim_prot_timer_bank;
  localparam int N = 6;
  localparam int D = 7;
  localparam int BASE0 = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    run_b = '0;
  logic [N-1:0]    rst_b = '0;
  logic [0:0][3:0] mult_b = '0;
  logic [N-1:0]    runout;

  int terms [N] = '{BASE0, 300, 4, 1, 0, 300};

  always #10 clk = ~clk;

  prot_timer_bank #(
    .N_CH(N), .N_MUL(1), .N_LONG(1), .REG_W(8), .SC_REGS(3), .MUL_W(4),
    .TICK_DIV(D),
    .TERM_TBL({32'd300, 32'd0, 32'd1, 32'd4, 32'd300, 32'd3})
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run_b), .rst_req_i(rst_b),
    .mult_i(mult_b), .runout_o(runout)
  );

  int    n_chk = 0, n_fail = 0;
  bit    done = 1'b0;
  bit    comparing = 1'b0;
  string tag = "R9";

  // requirement model: visit n of channel c lands on edge n*D+1+c
  longint cyc;
  int     m_cnt [N];
  bit     m_ro [N];
  bit     m_pend [N];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc = 0;
      for (int c = 0; c < N; c++) begin m_cnt[c] = 0; m_ro[c] = 0; m_pend[c] = 0; end
    end else begin
      cyc = cyc + 1;
      for (int c = 0; c < N; c++) begin
        int t;
        m_pend[c] = m_pend[c] | rst_b[c];
        if (cyc >= D + 1 + c && ((cyc - 1 - c) % D) == 0) begin
          t = (c == 0) ? BASE0 * int'(mult_b[0]) : terms[c];
          if (m_pend[c]) begin
            m_cnt[c] = 0; m_ro[c] = 0; m_pend[c] = 0;
          end else if (run_b[c] && !m_ro[c]) begin
            if (t == 0 || m_cnt[c] + 1 >= t) begin m_cnt[c] = t; m_ro[c] = 1; end
            else m_cnt[c] = m_cnt[c] + 1;
          end
        end
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      if (n_fail <= 30) $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (comparing && rst_n && !done)
      for (int c = 0; c < N; c++)
        chk(runout[c] == m_ro[c], $sformatf("%s model ch%0d runout", tag, c), int'(runout[c]), int'(m_ro[c]));
  end

  task automatic ticks(int n);
    repeat (n * D) @(negedge clk);
  endtask

  task automatic pulse_rst(int c);
    rst_b[c] = 1'b1;
    @(negedge clk);
    rst_b[c] = 1'b0;
  endtask

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog (R1) actual=running expected=finished");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(runout == '0, "R9 runout in reset", int'(runout), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(runout == '0, "R9 runout after release", int'(runout), 0);
    comparing = 1'b1;

    // several channels with different terminals in parallel
    tag = "R1 R3 R8";
    run_b[2] = 1'b1; run_b[3] = 1'b1; run_b[4] = 1'b1;
    ticks(8);
    chk(runout[4] == 1'b1, "R3 terminal 0 ch4", int'(runout[4]), 1);
    chk(runout[3] == 1'b1, "R3 terminal 1 ch3", int'(runout[3]), 1);
    chk(runout[2] == 1'b1, "R3 terminal 4 ch2", int'(runout[2]), 1);
    chk(runout[1:0] == 2'b00, "R8 idle channels untouched", int'(runout[1:0]), 0);

    tag = "R4";
    run_b[2] = 1'b0;
    pulse_rst(2);
    ticks(2);
    chk(runout[2] == 1'b0, "R4 reset cleared ch2", int'(runout[2]), 0);
    chk(runout[3] == 1'b1, "R8 ch3 unaffected by ch2 reset", int'(runout[3]), 1);

    tag = "R5";
    pulse_rst(3);
    ticks(3);
    chk(runout[3] == 1'b1, "R5 ch3 reruns after reset slot", int'(runout[3]), 1);

    tag = "R2";
    run_b[2] = 1'b1; ticks(2);
    run_b[2] = 1'b0; ticks(5);
    chk(runout[2] == 1'b0, "R2 stopped ch2 holds", int'(runout[2]), 0);
    run_b[2] = 1'b1; ticks(1);
    chk(runout[2] == 1'b0, "R2 ch2 count 3 of 4", int'(runout[2]), 0);
    ticks(1);
    chk(runout[2] == 1'b1, "R2 ch2 resumes to terminal", int'(runout[2]), 1);

    tag = "R6";
    run_b[1] = 1'b1; run_b[5] = 1'b1;
    ticks(299);
    chk(runout[1] == 1'b0, "R6 ch1 before 300", int'(runout[1]), 0);
    chk(runout[5] == 1'b0, "R6 ch5 before 300", int'(runout[5]), 0);
    ticks(1);
    chk(runout[1] == 1'b1, "R6 ch1 at 300", int'(runout[1]), 1);
    chk(runout[5] == 1'b1, "R6 ch5 at 300", int'(runout[5]), 1);

    tag = "R7";
    for (int m = 0; m < 16; m++) begin
      int e;
      run_b[0] = 1'b0;
      pulse_rst(0);
      ticks(2);
      chk(runout[0] == 1'b0, $sformatf("R7 ch0 cleared m=%0d", m), int'(runout[0]), 0);
      mult_b[0] = 4'(m);
      run_b[0] = 1'b1;
      e = (m == 0) ? 1 : BASE0 * m;
      if (e > 1) begin
        ticks(e - 1);
        chk(runout[0] == 1'b0, $sformatf("R7 ch0 early m=%0d", m), int'(runout[0]), 0);
        ticks(1);
      end else begin
        ticks(1);
      end
      chk(runout[0] == 1'b1, $sformatf("R7 ch0 due m=%0d", m), int'(runout[0]), 1);
    end

    comparing = 1'b0;
    done = 1'b1;
    report();
  end

endmodule